// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block decides which local interrupt a hart should take next. It keeps a 16-bit pending register. An enable mask is applied to that register, and the result is split into three delegation tiers using two delegation masks supplied from outside:
- **Machine tier:** bits not delegated away from machine level.
- **Host-supervisor tier:** bits delegated by the machine mask only.
- **Guest-supervisor tier:** bits delegated by both masks.

Each tier is admitted by its own rule. That rule depends on the current privilege level, the virtualization flag and the two global interrupt-enable bits. Among the bits that survive, the lowest index is reported together with a valid flag. The index and flag are registered.

Interrupt sources and software change the pending register through a masked write port. A write replaces only the bits selected by the mask. The value the register held before the write is returned in the following cycle. A request line stays high whenever any pending bit is set. Trap entry, instruction decode and external interrupt controllers sit outside this block.

Top module: `irq_tier_select`

## Requirements
- R1: Only bits set in both the pending register and `irq_enable` can be selected.
- R2: A candidate whose `mach_deleg` bit is 0 is admitted only when `priv` is below 3 (machine), or when `priv` is 3 and `glb_mie` is 1. Privilege encoding: 0 = user, 1 = supervisor, 3 = machine.
- R3: A candidate with `mach_deleg` 1 and `hyp_deleg` 0 is admitted when `virt_on` is 1 or the supervisor enable is true. The supervisor enable is true when `priv` is 0, or when `priv` is 1 and `glb_sie` is 1.
- R4: A candidate with both `mach_deleg` and `hyp_deleg` set is admitted only when `virt_on` is 1 and the supervisor enable (as in R3) is true.
- R5: When several bits are admitted, `take_idx` gives the lowest-numbered one and `take_valid` is 1. When none is admitted, `take_valid` is 0 and `take_idx` is 0.
- R6: On a clock edge with `upd_en` high, the pending register becomes (old AND NOT `upd_mask`) OR (`upd_val` AND `upd_mask`). Without `upd_en` it holds its value.
- R7: In the cycle after a write, `upd_old` shows the pending value from just before that write. `upd_old` changes only on writes.
- R8: `hard_req` is 1 exactly when the pending register is nonzero.
- R9: After a synchronous active-low reset, the pending register, `upd_old`, `take_valid` and `take_idx` are all zero.
- R10: `take_valid` and `take_idx` reflect the pending register and the inputs of the previous cycle, registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en | input | 1 | Apply a masked write to the pending register |
| upd_mask | input | 16 | Bits to replace |
| upd_val | input | 16 | New values for the masked bits |
| upd_old | output | 16 | Pending value before the last write |
| hard_req | output | 1 | High while any pending bit is set |
| irq_enable | input | 16 | Per-interrupt enable |
| mach_deleg | input | 16 | Machine-level delegation mask |
| hyp_deleg | input | 16 | Hypervisor-level delegation mask |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_on | input | 1 | Virtualization active |
| glb_mie | input | 1 | Global machine interrupt enable |
| glb_sie | input | 1 | Global supervisor interrupt enable |
| take_valid | output | 1 | An interrupt qualifies |
| take_idx | output | 4 | Index of the chosen interrupt |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Machine privilege with the global machine enable clear.** A design that ignored the enable would still report machine-tier interrupts.
- **Guest-supervisor bits with virtualization off.** A tier rule that used OR instead of AND would leak these bits through.
- **Several admitted bits across different tiers.** A picker that scanned from the top would report the highest index instead of the lowest.
- **Partial-mask writes.** These catch a write that touches unmasked bits, returns the new value instead of the old one, or leaves the request line out of step with the register.

// File: rtl/irq_sel_pkg.sv
// Package: shared widths and privilege encoding for the interrupt selector.
// Assumes privilege code 2 is unused; it falls through the same formulas.
package irq_sel_pkg;
    localparam int unsigned IRQ_W  = 16;
    localparam int unsigned IDX_W  = $clog2(IRQ_W);
    localparam logic [1:0]  PRIV_U = 2'd0;
    localparam logic [1:0]  PRIV_S = 2'd1;
    localparam logic [1:0]  PRIV_M = 2'd3;
endpackage

// File: rtl/irq_pend_reg.sv
// Pending register with a masked write port.
// A write keeps unmasked bits and replaces masked ones; the prior value is
// captured into old_q. Assumes a synchronous active-low reset.
module irq_pend_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] old_q,
    output logic         any_set
);
    // Holds pending state and the pre-write snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            old_q  <= '0;
        end else if (wr_en) begin
            pend_q <= (pend_q & ~wr_mask) | (wr_val & wr_mask);
            old_q  <= pend_q;
        end
    end

    // Request line follows register contents.
    assign any_set = |pend_q;

    // R6
    pend_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pend_q == (($past(pend_q) & ~$past(wr_mask)) | ($past(wr_val) & $past(wr_mask))));
    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pend_q));
    // R7
    old_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> old_q == $past(pend_q));
endmodule

// File: rtl/irq_tier_gate.sv
// Splits enabled pending bits into three delegation tiers and admits each
// tier under its own rule. Purely combinational.
module irq_tier_gate
    import irq_sel_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] en,
    input  logic [W-1:0] m_deleg,
    input  logic [W-1:0] h_deleg,
    input  logic [1:0]   priv,
    input  logic         virt,
    input  logic         mie,
    input  logic         sie,
    output logic [W-1:0] qual
);
    logic m_ok, s_ok, hs_ok, vs_ok;

    // Tier admission rules from privilege and global enables.
    always_comb begin
        m_ok  = (priv < PRIV_M) || (priv == PRIV_M && mie);
        s_ok  = (priv < PRIV_S) || (priv == PRIV_S && sie);
        hs_ok = virt || s_ok;
        vs_ok = virt && s_ok;
    end

    // Per-bit tier selection.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic gate;
        assign gate    = !m_deleg[i] ? m_ok : (!h_deleg[i] ? hs_ok : vs_ok);
        assign qual[i] = pend[i] & en[i] & gate;
    end

    // R1
    cand_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qual & ~(pend & en)) == '0);
    // R4
    guest_tier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !virt |-> (qual & m_deleg & h_deleg) == '0);
    // R2
    mach_tier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == PRIV_M && !mie) |-> (qual & ~m_deleg) == '0);
endmodule

// File: rtl/irq_low_pick.sv
// Finds the lowest set bit of a vector. Combinational; index is 0 when empty.
module irq_low_pick #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        found = |vec;
    end
endmodule

// File: rtl/irq_tier_select.sv
// Top: pending register, tier gating and lowest-index pick with a
// registered result. Assumes a synchronous active-low reset and that all
// control inputs are synchronous to clk.
module irq_tier_select
    import irq_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [IRQ_W-1:0]   upd_mask,
    input  logic [IRQ_W-1:0]   upd_val,
    output logic [IRQ_W-1:0]   upd_old,
    output logic               hard_req,
    input  logic [IRQ_W-1:0]   irq_enable,
    input  logic [IRQ_W-1:0]   mach_deleg,
    input  logic [IRQ_W-1:0]   hyp_deleg,
    input  logic [1:0]         priv,
    input  logic               virt_on,
    input  logic               glb_mie,
    input  logic               glb_sie,
    output logic               take_valid,
    output logic [IDX_W-1:0]   take_idx
);
    logic [IRQ_W-1:0] pend_q, qual_vec;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;

    irq_pend_reg #(.W(IRQ_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .wr_en(upd_en), .wr_mask(upd_mask),
        .wr_val(upd_val), .pend_q(pend_q), .old_q(upd_old), .any_set(hard_req)
    );

    irq_tier_gate #(.W(IRQ_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .pend(pend_q), .en(irq_enable),
        .m_deleg(mach_deleg), .h_deleg(hyp_deleg), .priv(priv),
        .virt(virt_on), .mie(glb_mie), .sie(glb_sie), .qual(qual_vec)
    );

    irq_low_pick #(.W(IRQ_W), .IW(IDX_W)) u_pick (
        .vec(qual_vec), .found(pick_found), .idx(pick_idx)
    );

    // Register the selection one cycle after its inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid <= 1'b0;
            take_idx   <= '0;
        end else begin
            take_valid <= pick_found;
            take_idx   <= pick_idx;
        end
    end

    // R5
    valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 take_valid == ($past(qual_vec) != '0));
    // R5
    chosen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 take_valid |-> (($past(qual_vec) >> take_idx) & IRQ_W'(1)) == IRQ_W'(1));
    // R5
    lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 take_valid |-> ($past(qual_vec) & ((IRQ_W'(1) << take_idx) - IRQ_W'(1))) == '0);
    // R8
    req_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req == (pend_q != '0));
endmodule

// File: tb/tb_irq_tier_select.sv
module tb_irq_tier_select;
    localparam int W = 16;
    logic clk = 1'b0, rst_n = 1'b0;
    logic upd_en = 1'b0;
    logic [W-1:0] upd_mask = '0, upd_val = '0, upd_old;
    logic hard_req;
    logic [W-1:0] irq_enable = '0, mach_deleg = '0, hyp_deleg = '0;
    logic [1:0] priv = 2'd0;
    logic virt_on = 1'b0, glb_mie = 1'b0, glb_sie = 1'b0;
    logic take_valid;
    logic [3:0] take_idx;

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] mdl_pend = '0;
    bit done = 0;

    irq_tier_select dut (.*);

    always #10 clk = ~clk;

    function automatic logic [W-1:0] ref_qual(logic [W-1:0] p, logic [W-1:0] e,
        logic [W-1:0] md, logic [W-1:0] hd, logic [1:0] pv, logic v, logic mi, logic si);
        logic mo, so;
        logic [W-1:0] q;
        mo = (pv < 2'd3) || (pv == 2'd3 && mi);
        so = (pv < 2'd1) || (pv == 2'd1 && si);
        q = '0;
        for (int i = 0; i < W; i++) begin
            if (p[i] && e[i]) begin
                if (!md[i]) q[i] = mo;
                else if (!hd[i]) q[i] = v || so;
                else q[i] = v && so;
            end
        end
        return q;
    endfunction

    function automatic int ref_low(logic [W-1:0] q);
        for (int i = 0; i < W; i++) if (q[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write pending register, check old value and request line (R6 R7 R8).
    task automatic do_write(input logic [W-1:0] m, input logic [W-1:0] v);
        logic [W-1:0] old;
        @(negedge clk);
        upd_en = 1'b1; upd_mask = m; upd_val = v;
        old = mdl_pend;
        mdl_pend = (mdl_pend & ~m) | (v & m);
        @(posedge clk); #1;
        upd_en = 1'b0;
        chk("R7 old", upd_old, old);
        chk("R8 req", hard_req, |mdl_pend);
    endtask

    // Apply selection inputs, check registered pick next edge (R2-R5 R10).
    task automatic do_sel(input string req, input logic [W-1:0] e, input logic [W-1:0] md,
        input logic [W-1:0] hd, input logic [1:0] pv, input logic v, input logic mi, input logic si);
        logic [W-1:0] q;
        @(negedge clk);
        irq_enable = e; mach_deleg = md; hyp_deleg = hd; priv = pv;
        virt_on = v; glb_mie = mi; glb_sie = si;
        q = ref_qual(mdl_pend, e, md, hd, pv, v, mi, si);
        @(posedge clk); #1;
        chk({req, " valid"}, take_valid, |q);
        chk({req, " idx"}, take_idx, ref_low(q));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 pend", hard_req, 1'b0);
        chk("R9 old", upd_old, 16'h0);
        chk("R9 valid", take_valid, 1'b0);
        chk("R9 idx", take_idx, 4'h0);
        @(negedge clk); rst_n = 1'b1;

        // R6 masked writes
        do_write(16'hFFFF, 16'hA5F0);
        do_write(16'h00FF, 16'h000F);
        chk("R6 write", upd_old, 16'hA5F0);
        do_write(16'h0000, 16'hFFFF);
        chk("R6 nomask", upd_old, 16'hA50F);
        // R1 enable zero hides everything
        do_sel("R1 none", 16'h0, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        // R2 machine priv, MIE clear blocks
        do_sel("R2 mie0", 16'hFFFF, 16'h0, 16'h0, 2'd3, 1'b0, 1'b0, 1'b1);
        do_sel("R2 mie1", 16'hFFFF, 16'h0, 16'h0, 2'd3, 1'b0, 1'b1, 1'b0);
        // R3 host tier at S with SIE clear, virt off vs on
        do_sel("R3 blocked", 16'hFFFF, 16'hFFFF, 16'h0, 2'd1, 1'b0, 1'b1, 1'b0);
        do_sel("R3 virt", 16'hFFFF, 16'hFFFF, 16'h0, 2'd1, 1'b1, 1'b0, 1'b0);
        // R4 guest tier needs virt and s-enable
        do_sel("R4 novirt", 16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b0);
        do_sel("R4 both", 16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd0, 1'b1, 1'b0, 1'b0);
        // R5 mixed tiers: low bits guest (blocked), higher host admitted
        do_sel("R5 mixed", 16'hFFFF, 16'hFFFF, 16'h00FF, 2'd1, 1'b0, 1'b0, 1'b1);
        // R5 top bit only
        do_write(16'hFFFF, 16'h8000);
        do_sel("R5 top", 16'hFFFF, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        do_write(16'hFFFF, 16'h0000);
        chk("R8 clear", hard_req, 1'b0);

        // R10 random mix
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 3) == 0)
                do_write(W'($urandom), W'($urandom));
            do_sel("R10 rand", W'($urandom), W'($urandom), W'($urandom),
                   2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule